// File: doc/BRIEF.md
# UART Receive Character Buffer with Line Status

This block sits between the receive shift stage of a UART and the CPU register interface. Each completed character arrives with a one-cycle strobe, its eight data bits and three per-character error flags (parity mismatch, missing stop bit, break). The block keeps the characters in a 16-entry first-in first-out store, or in one holding register when buffered mode is off. It also keeps the sticky and per-character status bits that a 16550-style line status register reports.

The CPU side has two read strobes. One pops the character at the head of the buffer. The other marks the status as read, which clears the sticky overrun bit and the error flags of the current head character. Error flags travel with their own character and become visible only when that character reaches the head. Overrun is reported as soon as it happens. A line-status interrupt is raised while any of the four error bits is set and the interrupt is enabled.

Top module: `rx_char_buffer`

## Requirements
- R1: With `fifo_en` high, up to 16 characters are held and returned in arrival order. `buf_data` always shows the oldest character, and a `rd_buf` pulse removes it.
- R2: With `fifo_en` low, there is a single holding register. A character that arrives while the register is occupied, with no `rd_buf` in the same cycle, replaces the old character and sets `st_oe`.
- R3: A `rd_stat` pulse clears `st_oe` and the parity, framing and break flags of the current head character, so a second read shows them clear. An overrun event in the same cycle keeps `st_oe` set. A character written into an empty buffer in the same cycle keeps its flags.
- R4: `st_pe`, `st_fe` and `st_bi` show the flags stored with the head character. They are low while the buffer is empty.
- R5: In buffered mode, a character that arrives while 16 are held, with no `rd_buf` in the same cycle, is discarded and the stored contents are unchanged. If `rd_buf` occurs in the same cycle, the character is accepted and no overrun is raised.
- R6: `st_oe` rises in the cycle after the overrun event, whatever flags the head character carries.
- R7: `st_dr` is high exactly while at least one character is buffered. A `rd_buf` on an empty buffer changes nothing. After reset the buffer is empty and all status bits are low.
- R8: `ls_irq` equals `lsi_en` AND (`st_oe` OR `st_pe` OR `st_fe` OR `st_bi`).
- R9: Any change of `fifo_en` discards every stored character and its flags; `st_dr` is low in the next cycle. A character arriving in the cycle of the change is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| fifo_en | input | 1 | 1 = 16-entry buffered mode, 0 = single holding register |
| lsi_en | input | 1 | Line-status interrupt enable |
| rx_valid | input | 1 | One-cycle strobe: a completed character is presented |
| rx_data | input | 8 | Received character |
| rx_par_err | input | 1 | Parity of this character did not match the selected parity |
| rx_frm_err | input | 1 | Stop bit of this character was sampled low |
| rx_brk | input | 1 | This character was a break condition |
| rd_buf | input | 1 | CPU read of the data buffer (pops the head) |
| rd_stat | input | 1 | CPU read of the line status |
| buf_data | output | 8 | Head character |
| st_dr | output | 1 | Data ready |
| st_oe | output | 1 | Overrun, sticky |
| st_pe | output | 1 | Parity error of head character |
| st_fe | output | 1 | Framing error of head character |
| st_bi | output | 1 | Break of head character |
| ls_irq | output | 1 | Line-status interrupt |

## Verification
The assertions assume that `rx_valid`, `rd_buf` and `rd_stat` are single-cycle pulses sampled at the rising edge. They also assume that `fifo_en` changes only between character strobes, so that a flush is never mistaken for an overrun. The stimulus drives every input on the falling edge and holds each strobe for exactly one cycle. Mode changes are made on cycles with no character present, except where the drop of a character during a flush is itself under test. Same-cycle collisions (push with pop when full, push with a status read, a status read during an overrun) are produced on purpose, because the ordering rules live there.

// File: rtl/rxb_pkg.sv
package rxb_pkg;
    localparam int CHAR_W = 8;

    typedef struct packed {
        logic              brk;
        logic              fe;
        logic              pe;
        logic [CHAR_W-1:0] data;
    } rxb_entry_t;
endpackage

// File: rtl/rxb_store.sv
module rxb_store
    import rxb_pkg::*;
#(
    parameter int DEPTH = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       fifo_en,
    input  logic       wr_req,
    input  rxb_entry_t wr_entry,
    input  logic       pop_req,
    input  logic       clr_tags,
    output rxb_entry_t head,
    output logic       not_empty,
    output logic       ovr_evt
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);

    typedef struct packed {
        rxb_entry_t [DEPTH-1:0] mem;
        logic [PTR_W-1:0]       rd_ptr;
        logic [PTR_W-1:0]       wr_ptr;
        logic [CNT_W-1:0]       cnt;
        logic                   mode;
    } st_t;

    st_t s_q, s_d;

    logic             flush;
    logic             do_pop;
    logic             room;
    logic             accept;
    logic [PTR_W-1:0] slot;
    logic [CNT_W-1:0] cap;

    function automatic logic [PTR_W-1:0] ptr_inc(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_comb begin
        flush   = (fifo_en != s_q.mode);
        cap     = s_q.mode ? CNT_W'(DEPTH) : CNT_W'(1);
        do_pop  = pop_req && (s_q.cnt != '0);
        room    = (s_q.cnt < cap) || do_pop;
        accept  = wr_req && !flush && (room || !s_q.mode);
        ovr_evt = wr_req && !flush && !room;
        slot    = s_q.mode ? s_q.wr_ptr : '0;

        s_d      = s_q;
        s_d.mode = fifo_en;
        if (flush) begin
            s_d.rd_ptr = '0;
            s_d.wr_ptr = '0;
            s_d.cnt    = '0;
        end else begin
            if (clr_tags && (s_q.cnt != '0)) begin
                s_d.mem[s_q.rd_ptr].pe  = 1'b0;
                s_d.mem[s_q.rd_ptr].fe  = 1'b0;
                s_d.mem[s_q.rd_ptr].brk = 1'b0;
            end
            if (do_pop && s_q.mode) begin
                s_d.rd_ptr = ptr_inc(s_q.rd_ptr);
            end
            if (accept) begin
                s_d.mem[slot] = wr_entry;
                if (s_q.mode) begin
                    s_d.wr_ptr = ptr_inc(s_q.wr_ptr);
                end
            end
            if (s_q.mode) begin
                s_d.cnt = s_q.cnt + CNT_W'(accept) - CNT_W'(do_pop);
            end else if (accept) begin
                s_d.cnt = CNT_W'(1);
            end else if (do_pop) begin
                s_d.cnt = '0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign head      = s_q.mem[s_q.rd_ptr];
    assign not_empty = (s_q.cnt != '0);

    AST_CNT_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.cnt <= CNT_W'(DEPTH)); // R1

    AST_SINGLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !s_q.mode |-> (s_q.cnt <= CNT_W'(1))); // R2

    AST_FULL_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.mode && fifo_en && (s_q.cnt == CNT_W'(DEPTH)) && wr_req && !pop_req)
        |=> ((s_q.cnt == CNT_W'(DEPTH)) && $stable(s_q.wr_ptr))); // R5

    AST_LAST_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (pop_req && (s_q.cnt == CNT_W'(1)) && !wr_req) |=> !not_empty); // R7

    AST_FLUSH_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        (fifo_en != s_q.mode) |=> !not_empty); // R9
endmodule

// File: rtl/rxb_status.sv
module rxb_status
    import rxb_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ovr_evt,
    input  logic       rd_stat,
    input  logic       irq_en,
    input  rxb_entry_t head,
    input  logic       not_empty,
    output logic       st_oe,
    output logic       st_pe,
    output logic       st_fe,
    output logic       st_bi,
    output logic       ls_irq
);
    typedef struct packed {
        logic oe;
    } st_t;

    st_t s_q, s_d;

    always_comb begin
        s_d = s_q;
        if (ovr_evt) begin
            s_d.oe = 1'b1;
        end else if (rd_stat) begin
            s_d.oe = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign st_oe  = s_q.oe;
    assign st_pe  = not_empty && head.pe;
    assign st_fe  = not_empty && head.fe;
    assign st_bi  = not_empty && head.brk;
    assign ls_irq = irq_en && (st_oe || st_pe || st_fe || st_bi);

    AST_OE_IMMEDIATE: assert property (@(posedge clk) disable iff (!rst_n)
        ovr_evt |=> st_oe); // R6

    AST_OE_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_stat && !ovr_evt) |=> !st_oe); // R3
endmodule

// File: rtl/rx_char_buffer.sv
module rx_char_buffer
    import rxb_pkg::*;
#(
    parameter int DEPTH = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fifo_en,
    input  logic              lsi_en,
    input  logic              rx_valid,
    input  logic [CHAR_W-1:0] rx_data,
    input  logic              rx_par_err,
    input  logic              rx_frm_err,
    input  logic              rx_brk,
    input  logic              rd_buf,
    input  logic              rd_stat,
    output logic [CHAR_W-1:0] buf_data,
    output logic              st_dr,
    output logic              st_oe,
    output logic              st_pe,
    output logic              st_fe,
    output logic              st_bi,
    output logic              ls_irq
);
    rxb_entry_t in_entry;
    rxb_entry_t head;
    logic       not_empty;
    logic       ovr_evt;

    always_comb begin
        in_entry.data = rx_data;
        in_entry.pe   = rx_par_err;
        in_entry.fe   = rx_frm_err;
        in_entry.brk  = rx_brk;
    end

    rxb_store #(
        .DEPTH(DEPTH)
    ) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .fifo_en  (fifo_en),
        .wr_req   (rx_valid),
        .wr_entry (in_entry),
        .pop_req  (rd_buf),
        .clr_tags (rd_stat),
        .head     (head),
        .not_empty(not_empty),
        .ovr_evt  (ovr_evt)
    );

    rxb_status u_status (
        .clk      (clk),
        .rst_n    (rst_n),
        .ovr_evt  (ovr_evt),
        .rd_stat  (rd_stat),
        .irq_en   (lsi_en),
        .head     (head),
        .not_empty(not_empty),
        .st_oe    (st_oe),
        .st_pe    (st_pe),
        .st_fe    (st_fe),
        .st_bi    (st_bi),
        .ls_irq   (ls_irq)
    );

    assign buf_data = head.data;
    assign st_dr    = not_empty;
endmodule

// File: tb/rx_char_buffer_tb.sv
`timescale 1ns/1ps
module rx_char_buffer_tb;
    import rxb_pkg::*;

    localparam int DEPTH = 16;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       fifo_en = 1'b0;
    logic       lsi_en = 1'b0;
    logic       rx_valid = 1'b0;
    logic [7:0] rx_data = '0;
    logic       rx_par_err = 1'b0;
    logic       rx_frm_err = 1'b0;
    logic       rx_brk = 1'b0;
    logic       rd_buf = 1'b0;
    logic       rd_stat = 1'b0;
    logic [7:0] buf_data;
    logic       st_dr, st_oe, st_pe, st_fe, st_bi, ls_irq;

    int         n_cmp = 0;
    int         n_bad = 0;
    bit         done = 1'b0;
    rxb_entry_t sb[$];
    bit         m_oe = 1'b0;
    bit         m_mode = 1'b0;

    always #2.5 clk = ~clk;

    rx_char_buffer #(.DEPTH(DEPTH)) u_dut (
        .clk(clk), .rst_n(rst_n), .fifo_en(fifo_en), .lsi_en(lsi_en),
        .rx_valid(rx_valid), .rx_data(rx_data), .rx_par_err(rx_par_err),
        .rx_frm_err(rx_frm_err), .rx_brk(rx_brk), .rd_buf(rd_buf),
        .rd_stat(rd_stat), .buf_data(buf_data), .st_dr(st_dr), .st_oe(st_oe),
        .st_pe(st_pe), .st_fe(st_fe), .st_bi(st_bi), .ls_irq(ls_irq)
    );

    function automatic rxb_entry_t mk(logic [7:0] d, bit p, bit f, bit b);
        rxb_entry_t e;
        e.data = d; e.pe = p; e.fe = f; e.brk = b;
        return e;
    endfunction

    task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // Driver: one cycle of stimulus, expected state pushed into the scoreboard
    task automatic cycle(bit push, rxb_entry_t e, bit rd, bit st);
        rxb_entry_t t;
        int         cap;
        @(negedge clk);
        rx_valid = push; rx_data = e.data; rx_par_err = e.pe;
        rx_frm_err = e.fe; rx_brk = e.brk; rd_buf = rd; rd_stat = st;
        if (st) begin
            m_oe = 1'b0;
            if (sb.size() > 0) begin
                t = sb[0]; t.pe = 1'b0; t.fe = 1'b0; t.brk = 1'b0; sb[0] = t;
            end
        end
        if (rd && sb.size() > 0) void'(sb.pop_front());
        if (push) begin
            cap = m_mode ? DEPTH : 1;
            if (sb.size() < cap) sb.push_back(e);
            else begin
                m_oe = 1'b1;
                if (!m_mode) sb[0] = e;
            end
        end
        @(negedge clk);
        rx_valid = 1'b0; rd_buf = 1'b0; rd_stat = 1'b0;
        rx_par_err = 1'b0; rx_frm_err = 1'b0; rx_brk = 1'b0;
    endtask

    // Monitor: compare the ports against the scoreboard head
    task automatic monitor(string req);
        bit ne;
        bit hp, hf, hb;
        #0.5;
        ne = (sb.size() > 0);
        hp = ne && sb[0].pe; hf = ne && sb[0].fe; hb = ne && sb[0].brk;
        chk(req, "st_dr", st_dr, ne);
        chk(req, "st_oe", st_oe, m_oe);
        chk(req, "st_pe", st_pe, hp);
        chk(req, "st_fe", st_fe, hf);
        chk(req, "st_bi", st_bi, hb);
        if (ne) chk(req, "buf_data", buf_data, sb[0].data);
        chk(req, "ls_irq", ls_irq, lsi_en && (m_oe || hp || hf || hb));
    endtask

    task automatic set_mode(bit m);
        @(negedge clk);
        fifo_en = m;
        if (m != m_mode) sb.delete();
        m_mode = m;
        @(negedge clk);
    endtask

    initial begin
        #1000000;
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        monitor("R7");

        set_mode(1'b1);
        monitor("R9");
        lsi_en = 1'b1;

        // R4: flags ride with their own characters
        cycle(1, mk(8'h11, 0, 0, 0), 0, 0); monitor("R4");
        cycle(1, mk(8'h22, 0, 1, 0), 0, 0); monitor("R4");
        cycle(1, mk(8'h33, 1, 0, 0), 0, 0); monitor("R4");
        cycle(1, mk(8'h44, 0, 0, 1), 0, 0); monitor("R4");
        cycle(1, mk(8'h55, 0, 0, 0), 0, 0); monitor("R4");
        cycle(0, mk(0, 0, 0, 0), 1, 0); monitor("R1");
        monitor("R8");
        lsi_en = 1'b0; monitor("R8");
        lsi_en = 1'b1;
        // R3: status read clears head flags, second read stays clear
        cycle(0, mk(0, 0, 0, 0), 0, 1); monitor("R3");
        cycle(0, mk(0, 0, 0, 0), 0, 1); monitor("R3");
        for (int i = 0; i < 4; i++) begin
            cycle(0, mk(0, 0, 0, 0), 1, 0); monitor("R1");
        end
        cycle(0, mk(0, 0, 0, 0), 1, 0); monitor("R7");

        // Fill to full
        for (int i = 0; i < DEPTH; i++) begin
            cycle(1, mk(8'h80 + 8'(i), i == 3, 0, 0), 0, 0);
        end
        monitor("R1");
        cycle(1, mk(8'hEE, 0, 0, 0), 0, 0); monitor("R5");
        monitor("R6");
        cycle(1, mk(8'hEF, 0, 1, 0), 1, 0); monitor("R5");
        cycle(1, mk(8'hF0, 0, 0, 0), 0, 1); monitor("R3");
        cycle(0, mk(0, 0, 0, 0), 0, 1); monitor("R3");
        for (int i = 0; i < DEPTH; i++) begin
            cycle(0, mk(0, 0, 0, 0), 1, 0); monitor("R1");
        end
        monitor("R7");

        // R3: character entering an empty buffer keeps its flags
        cycle(1, mk(8'h5A, 1, 0, 0), 0, 1); monitor("R3");

        // R9: mode change flushes
        cycle(1, mk(8'h66, 0, 0, 0), 0, 0);
        set_mode(1'b0); monitor("R9");

        // R2: single holding register
        cycle(1, mk(8'hA1, 0, 0, 0), 0, 0); monitor("R2");
        cycle(1, mk(8'hB2, 0, 1, 0), 0, 0); monitor("R2");
        cycle(0, mk(0, 0, 0, 0), 0, 1); monitor("R2");
        cycle(1, mk(8'hC3, 0, 0, 0), 1, 0); monitor("R2");
        cycle(0, mk(0, 0, 0, 0), 1, 0); monitor("R7");
        cycle(0, mk(0, 0, 0, 0), 1, 0); monitor("R7");

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule